// File: doc/BRIEF.md
# Memory Data-Bus Line Checker

This controller checks the data wires between a chip and an external RAM for shorts and opens before any deeper memory testing. A one-cycle start pulse launches a run. The block then works through twelve fixed 64-bit patterns. The first six make every pair of data bits take opposite values under any wire routing, and the last six are their complements. All of them go to one word address, the base of the region under test.

For each pattern the block makes three transfers on a simple word-wide memory port. It writes the pattern to the base word, then writes a fixed guard word to the next word up, then reads the base word back. The guard write drives the bus to a different value, so charge left on a floating wire cannot echo the pattern back and hide a fault. The block takes the read data exactly once, on the read-valid strobe, and compares it with the pattern.

At the end it pulses done and shows pass or fail. It also keeps a record of the first failing pattern: its index, the expected word and the word actually read.

Top module: `mem_dline_checker`

## Requirements
- R1: After reset the block is idle. mem_req, busy, done, pass and fail_seen are all 0.
- R2: Patterns are applied in this fixed order, index 0 to 11: AAAAAAAAAAAAAAAA, CCCCCCCCCCCCCCCC, F0F0F0F0F0F0F0F0, FF00FF00FF00FF00, FFFF0000FFFF0000, FFFFFFFF00000000, 00000000FFFFFFFF, 0000FFFF0000FFFF, 00FF00FF00FF00FF, 0F0F0F0F0F0F0F0F, 3333333333333333, 5555555555555555.
- R3: For each pattern there are exactly three accepted transfers, in this order:
  - a write of the pattern to the base word address;
  - a write of 0x0123456789ABCDEF to base+1;
  - a single read of the base address.
- R4: A transfer is accepted in a cycle where mem_req and mem_ready are both high. While mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold their values.
- R5: Read data is taken only in a cycle with mem_rvalid high. mem_rdata in other cycles is ignored, and any read latency is allowed.
- R6: pass is 1 at the end of a run only if all twelve read-backs equal their patterns. Otherwise it is 0.
- R7: All twelve patterns are run, giving 36 transfers, even after a mismatch.
- R8: On the first mismatch of a run, fail_seen goes to 1 and the record latches three values:
  - fail_index, the pattern index in the R2 order;
  - fail_expect, the pattern;
  - fail_actual, the word read.

  Later mismatches in the same run leave the record unchanged.
- R9: done is high for exactly one cycle at the end of a run. busy is high from the cycle after start is accepted until the end. pass and the fail record stay stable until the next accepted start, which clears them.
- R10: A start pulse while busy is high has no effect on the run: no extra transfers, same addresses, same result.
- R11: The base address is sampled when start is accepted. Later changes of base_addr do not affect the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| base_addr | input | 16 | Word address of the target location |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last completed run |
| fail_seen | output | 1 | A mismatch was recorded in this run |
| fail_index | output | 4 | Pattern index of the first mismatch |
| fail_expect | output | 64 | Pattern written at the first mismatch |
| fail_actual | output | 64 | Word read at the first mismatch |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 64 | Read data |

## Verification
The assertions assume the memory answers each accepted read with exactly one mem_rvalid pulse, and only after the request was accepted. They also assume mem_ready may drop at any time but eventually returns.

The bench memory model keeps to this contract. It returns one response per accepted read after a programmable delay, and shows junk on mem_rdata whenever mem_rvalid is low. Stalls come from a fixed ready duty cycle, never from a permanent hold.

Faults are injected only on the read path: a stuck bit, or a byte lane that echoes the last word written to the bus. This way the request side always behaves as the assertions expect.

// File: rtl/mem_dline_checker.sv
module mem_dline_checker #(
  parameter int DW = 64,
  parameter int AW = 16,
  parameter logic [DW-1:0] GUARD = 64'h0123_4567_89AB_CDEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail_seen,
  output logic [$clog2(2*$clog2(DW))-1:0] fail_index,
  output logic [DW-1:0] fail_expect,
  output logic [DW-1:0] fail_actual,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW   = $clog2(DW);
  localparam int NPAT = 2 * PW;
  localparam int IW   = $clog2(NPAT);

  typedef enum logic [2:0] {S_IDLE, S_WPAT, S_WGRD, S_RREQ, S_RWAIT} st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;
  logic          err;

  function automatic logic [DW-1:0] pat_of(input logic [IW-1:0] k);
    logic [DW-1:0] p;
    int s;
    s = (int'(k) < PW) ? int'(k) : (NPAT - 1 - int'(k));
    for (int b = 0; b < DW; b++) p[b] = ((b >> s) & 1) != 0;
    return (int'(k) < PW) ? p : ~p;
  endfunction

  logic [DW-1:0] cur_pat;
  logic          go, last, miss;

  assign cur_pat   = pat_of(idx);
  assign go        = (st == S_IDLE) && start;
  assign last      = (int'(idx) == NPAT - 1);
  assign miss      = mem_rdata != cur_pat;
  assign busy      = st != S_IDLE;
  assign mem_req   = (st == S_WPAT) || (st == S_WGRD) || (st == S_RREQ);
  assign mem_we    = (st == S_WPAT) || (st == S_WGRD);
  assign mem_addr  = (st == S_WGRD) ? base_q + AW'(1) : base_q;
  assign mem_wdata = (st == S_WGRD) ? GUARD : (st == S_WPAT) ? cur_pat : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      idx         <= '0;
      base_q      <= '0;
      err         <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail_seen   <= 1'b0;
      fail_index  <= '0;
      fail_expect <= '0;
      fail_actual <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q    <= base_addr;
          idx       <= '0;
          err       <= 1'b0;
          pass      <= 1'b0;
          fail_seen <= 1'b0;
          st        <= S_WPAT;
        end
        S_WPAT: if (mem_ready) st <= S_WGRD;
        S_WGRD: if (mem_ready) st <= S_RREQ;
        S_RREQ: if (mem_ready) st <= S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          if (miss) begin
            err <= 1'b1;
            if (!fail_seen) begin
              fail_seen   <= 1'b1;
              fail_index  <= idx;
              fail_expect <= cur_pat;
              fail_actual <= mem_rdata;
            end
          end
          if (last) begin
            st   <= S_IDLE;
            done <= 1'b1;
            pass <= !(err || miss);
          end else begin
            idx <= idx + IW'(1);
            st  <= S_WPAT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> !mem_req);

  assert_guard_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_wdata == GUARD |-> mem_addr == base_q + AW'(1));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_pass_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pass != $past(pass) |-> done || $past(go));

  assert_record_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_seen && !go |=> fail_seen && $stable(fail_index) && $stable(fail_expect) && $stable(fail_actual));
endmodule

// File: tb/test_mem_dline_checker.sv
module test_mem_dline_checker;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] base_addr = '0;
  logic busy, done, pass, fail_seen;
  logic [3:0] fail_index;
  logic [63:0] fail_expect, fail_actual, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_ready, mem_rvalid;
  logic [15:0] mem_addr;

  mem_dline_checker i_mem_dline_checker (.clk, .rst_n, .start, .base_addr, .busy, .done, .pass,
    .fail_seen, .fail_index, .fail_expect, .fail_actual, .mem_req, .mem_we, .mem_addr,
    .mem_wdata, .mem_ready, .mem_rvalid, .mem_rdata);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  localparam logic [63:0] GRD = 64'h0123456789ABCDEF;
  logic [63:0] pats [0:11] = '{64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'hF0F0F0F0F0F0F0F0,
    64'hFF00FF00FF00FF00, 64'hFFFF0000FFFF0000, 64'hFFFFFFFF00000000, 64'h00000000FFFFFFFF,
    64'h0000FFFF0000FFFF, 64'h00FF00FF00FF00FF, 64'h0F0F0F0F0F0F0F0F, 64'h3333333333333333,
    64'h5555555555555555};

  // memory model and fault controls
  logic [63:0] ram [0:15];
  logic [63:0] or_mask = '0, float_mask = '0, last_bus = '0;
  int lat = 0, tick = 0, cnt = 0;
  bit stall_en = 0, pend = 0;
  logic [3:0] pend_a;
  logic        log_we [0:63];
  logic [15:0] log_a  [0:63];
  logic [63:0] log_d  [0:63];
  int log_n = 0;

  always @(posedge clk) begin
    tick <= tick + 1;
    mem_ready <= !stall_en || (tick % 3 == 2);
    mem_rvalid <= 1'b0;
    mem_rdata <= 64'hDEADBEEFDEADBEEF;
    if (pend) begin
      if (cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= ((ram[pend_a] & ~float_mask) | (last_bus & float_mask)) | or_mask;
        pend <= 0;
      end else cnt <= cnt - 1;
    end
    if (mem_req && mem_ready) begin
      if (log_n < 64) begin
        log_we[log_n] <= mem_we; log_a[log_n] <= mem_addr; log_d[log_n] <= mem_wdata;
      end
      log_n <= log_n + 1;
      if (mem_we) begin ram[mem_addr[3:0]] <= mem_wdata; last_bus <= mem_wdata; end
      else begin pend <= 1; cnt <= lat; pend_a <= mem_addr[3:0]; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  // run one test and check everything against expectation
  task automatic run(input logic [15:0] base, input bit exp_pass, input int exp_idx,
                     input logic [63:0] exp_act, input bit poke);
    int bad = 0, n = 0, dn = 0;
    @(negedge clk); log_n = 0; base_addr = base; start = 1;
    @(negedge clk); start = 0;
    chk(busy, "R9 busy after start", 64'(busy), 1);
    while (!done && n < 2000) begin
      if (poke && n == 10) begin start = 1; base_addr = base + 16'd2; end
      else begin start = 0; base_addr = base + 16'd5; end
      @(negedge clk); n++;
      if (done) dn++;
    end
    start = 0;
    @(negedge clk);
    chk(!done, "R9 done one cycle", 64'(done), 0);
    chk(!busy, "R9 busy low at end", 64'(busy), 0);
    chk(log_n == 36, "R7 R10 transfer count", 64'(log_n), 36);
    for (int k = 0; k < 36 && k < log_n; k++) begin
      int p = k / 3;
      case (k % 3)
        0: if (!(log_we[k] && log_a[k] == base && log_d[k] == pats[p])) bad++;
        1: if (!(log_we[k] && log_a[k] == base + 16'd1 && log_d[k] == GRD)) bad++;
        default: if (!(!log_we[k] && log_a[k] == base)) bad++;
      endcase
    end
    chk(bad == 0, "R2 R3 R11 transfer sequence", 64'(bad), 0);
    chk(pass == exp_pass, "R6 pass", 64'(pass), 64'(exp_pass));
    chk(fail_seen == !exp_pass, "R8 fail_seen", 64'(fail_seen), 64'(!exp_pass));
    if (!exp_pass) begin
      chk(fail_index == exp_idx, "R8 fail_index", 64'(fail_index), 64'(exp_idx));
      chk(fail_expect == pats[exp_idx], "R8 fail_expect", fail_expect, pats[exp_idx]);
      chk(fail_actual == exp_act, "R8 fail_actual", fail_actual, exp_act);
    end
    repeat (5) @(negedge clk);
    chk(pass == exp_pass && !done, "R9 result held", 64'(pass), 64'(exp_pass));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!mem_req && !busy && !done && !pass && !fail_seen, "R1 reset state",
        {59'd0, mem_req, busy, done, pass, fail_seen}, 0);
  endtask

  task automatic t_clean;            // R2 R3 R6
    stall_en = 0; lat = 0; or_mask = 0; float_mask = 0;
    run(16'h0004, 1, 0, 0, 0);
  endtask

  task automatic t_stall_latency;    // R4 R5
    stall_en = 1; lat = 3;
    run(16'h000A, 1, 0, 0, 0);
    stall_en = 0; lat = 0;
  endtask

  task automatic t_stuck_bit;        // R7 R8: bit 63 stuck at 1, first hit is index 6
    or_mask = 64'h8000000000000000;
    run(16'h0004, 0, 6, 64'h80000000FFFFFFFF, 0);
    or_mask = 0;
  endtask

  task automatic t_floating_lane;    // R8: byte 6 echoes the guard write
    float_mask = 64'h00FF000000000000; lat = 2;
    run(16'h0004, 0, 0, 64'hAA23AAAAAAAAAAAA, 0);
    float_mask = 0; lat = 0;
  endtask

  task automatic t_start_busy;       // R10 R11: start and base changes while running
    stall_en = 1; lat = 1;
    run(16'h0004, 1, 0, 0, 1);
    stall_en = 0; lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_clean();
    t_stall_latency();
    t_stuck_bit();
    t_floating_lane();
    t_start_busy();
    t_clean();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule